// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This block sits after the ALU of a pipelined datapath. Each cycle it takes the two ALU operands, the ALU result and a flag saying whether the operation was a subtraction. A 4-bit code chooses one of sixteen conditions, and the block reduces the inputs to a single condition bit. The block does no arithmetic of its own. It only forms the tests the conditions need. Among these is a signed-overflow flag, which it builds from the operand and result signs. For a subtraction, the right operand is taken as negated.

The condition bit is registered, so it appears in the cycle after the operands are presented. When the trap-enable input is high and the chosen condition is true, a registered trap is raised in that same following cycle. The block also drives a carry-update enable for the datapath's carry register. This enable is withheld while the trap is up, and also while either the hold-carry input or the reject input is set.

The low three bits of the code pick a base test. The top bit of the code inverts that test, so every condition has its complement.

Top module: `cond_select_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cond_o` and `trap_o` are 0.
- R2: Code 0 yields 1 when `alu_out` is zero. Code 8 yields its inverse.
- R3: Code 1 yields `alu_out[31]` (result negative). Code 9 yields its inverse (result non-negative).
- R4: Code 2 yields 1 when `alu_out` is zero or `alu_out[31]` is set (result at most zero). Code 10 yields its inverse (result greater than zero).
- R5: Code 3 yields signed overflow: `op_left[31]` equals the sign of the effective right operand and differs from `alu_out[31]`. The effective right operand is the two's-complement negation of `op_right` when `is_sub` is 1, and `op_right` itself otherwise. Code 11 yields its inverse.
- R6: Code 12 yields 1 when `op_left[31]` is 0 and `alu_out[31]` is 1. Code 4 yields its inverse.
- R7: Code 5 yields 1 when bits 31 and 30 differ in any of `op_left`, `op_right` or `alu_out`. Code 13 yields its inverse.
- R8: Codes 6 and 7 always yield 0. Codes 14 and 15 always yield 1.
- R9: For every base code c in 0..7 and the same inputs, code c+8 yields the inverse of code c.
- R10: `cond_o` shows the condition for the inputs sampled at the previous rising clock edge, one cycle of latency.
- R11: `trap_o` is 1 exactly when, at the previous edge, `trap_en` was 1 and the chosen condition was true.
- R12: `carry_upd_o` is 0 whenever `trap_o`, `hold_carry` or `reject` is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_left | input | 32 | ALU left operand |
| op_right | input | 32 | ALU right operand |
| alu_out | input | 32 | ALU result |
| is_sub | input | 1 | Operation was a subtraction |
| cond_sel | input | 4 | Condition code: bit 3 inverts, bits 2:0 pick the base test |
| trap_en | input | 1 | Raise a trap if the condition is true |
| hold_carry | input | 1 | Hold the carry register this cycle |
| reject | input | 1 | Access rejected, so the carry is not updated |
| cond_o | output | 1 | Registered condition |
| trap_o | output | 1 | Registered trap |
| carry_upd_o | output | 1 | Carry register may update |

## Verification
A wrong flag shows on `cond_o` exactly one cycle after the inputs. It shows only when the code in use picks that flag, so the bench sweeps all sixteen codes over each operand pattern. A wrong complement bit or a wrong mux leg appears as a pair of codes that agree instead of differing. A fault in the trap register shows one cycle late on both `trap_o` and `carry_upd_o`. The subtraction negation matters only for operand pairs whose overflow result changes with `is_sub`, and the bench includes such pairs.

// File: rtl/cond_pkg.sv
package cond_pkg;

  typedef enum logic [2:0] {
    BASE_ZERO   = 3'd0,
    BASE_NEG    = 3'd1,
    BASE_LEZ    = 3'd2,
    BASE_OVF    = 3'd3,
    BASE_INBND  = 3'd4,
    BASE_BADTAG = 3'd5,
    BASE_NEVER0 = 3'd6,
    BASE_NEVER1 = 3'd7
  } base_cond_e;

  localparam int unsigned SEL_W   = 4;
  localparam int unsigned N_BASE  = 8;

  typedef struct packed {
    logic zero;
    logic neg;
    logic ovf;
    logic badtag;
    logic outbnd;
  } flag_set_t;

  function automatic logic f_top_pair_mismatch(input logic [1:0] top2);
    return top2[1] ^ top2[0];
  endfunction

  function automatic logic f_sign_overflow(input logic l_sign, input logic r_sign,
                                           input logic o_sign);
    return (l_sign == r_sign) && (l_sign != o_sign);
  endfunction

endpackage

// File: rtl/cond_flags.sv
module cond_flags
  import cond_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   left_top,
  input  logic [1:0]   right_top,
  input  logic [W-1:0] eff_right,
  input  logic [W-1:0] result,
  output flag_set_t    flags
);
  localparam int unsigned MSB = W - 1;
  localparam int unsigned N_OPS = 3;

  logic [N_OPS-1:0][1:0] tops;
  logic [N_OPS-1:0]      mism;
  logic [W-2:0]          unused_eff_lo;

  assign tops[0] = left_top;
  assign tops[1] = right_top;
  assign tops[2] = result[MSB -: 2];
  assign unused_eff_lo = eff_right[W-2:0];

  for (genvar g = 0; g < N_OPS; g++) begin : g_tag
    assign mism[g] = f_top_pair_mismatch(tops[g]);
  end

  always_comb begin
    flags.zero   = (result == '0);
    flags.neg    = result[MSB];
    flags.ovf    = f_sign_overflow(left_top[1], eff_right[MSB], result[MSB]);
    flags.badtag = |mism;
    flags.outbnd = !left_top[1] && result[MSB];
  end

  p_ovf_sign_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags.ovf |-> (left_top[1] != result[MSB]));
  p_zero_not_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags.zero |-> !flags.neg);
  p_outbnd_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flags.outbnd |-> flags.neg);
endmodule

// File: rtl/cond_mux.sv
module cond_mux
  import cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  flag_set_t        flags,
  input  logic [SEL_W-1:0] sel,
  output logic             cond
);
  logic [N_BASE-1:0] base_vec;
  logic              base_bit;

  always_comb begin
    base_vec = '0;
    base_vec[BASE_ZERO]   = flags.zero;
    base_vec[BASE_NEG]    = flags.neg;
    base_vec[BASE_LEZ]    = flags.zero | flags.neg;
    base_vec[BASE_OVF]    = flags.ovf;
    base_vec[BASE_INBND]  = !flags.outbnd;
    base_vec[BASE_BADTAG] = flags.badtag;
    base_vec[BASE_NEVER0] = 1'b0;
    base_vec[BASE_NEVER1] = 1'b0;
  end

  assign base_bit = base_vec[sel[2:0]];
  assign cond     = base_bit ^ sel[SEL_W-1];

  p_const_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2:1] == 2'b11) |-> (cond == sel[SEL_W-1]));
  p_zero_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'd0) |-> (cond == flags.zero));
endmodule

// File: rtl/cond_trap_reg.sv
module cond_trap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_d,
  input  logic trap_en,
  output logic cond_q,
  output logic trap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      cond_q <= cond_d;
      trap_q <= trap_en & cond_d;
    end
  end

  p_trap_needs_cond_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> cond_q);
  p_cond_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cond_q == $past(cond_d)));
endmodule

// File: rtl/cond_select_unit.sv
module cond_select_unit
  import cond_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_left,
  input  logic [W-1:0] op_right,
  input  logic [W-1:0] alu_out,
  input  logic         is_sub,
  input  logic [3:0]   cond_sel,
  input  logic         trap_en,
  input  logic         hold_carry,
  input  logic         reject,
  output logic         cond_o,
  output logic         trap_o,
  output logic         carry_upd_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] eff_right;
  flag_set_t    flags;
  logic         cond_d;
  logic [W-3:0] unused_left_lo;
  logic [W-3:0] unused_right_lo;

  assign unused_left_lo  = op_left[W-3:0];
  assign unused_right_lo = op_right[W-3:0];
  assign eff_right = is_sub ? (~op_right + 1'b1) : op_right;

  cond_flags #(.W(W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .left_top  (op_left[MSB -: 2]),
    .right_top (op_right[MSB -: 2]),
    .eff_right (eff_right),
    .result    (alu_out),
    .flags     (flags)
  );

  cond_mux u_mux (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (flags),
    .sel   (cond_sel),
    .cond  (cond_d)
  );

  cond_trap_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond_d  (cond_d),
    .trap_en (trap_en),
    .cond_q  (cond_o),
    .trap_q  (trap_o)
  );

  assign carry_upd_o = !(trap_o || hold_carry || reject);

  p_trap_blocks_carry_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !carry_upd_o);
  p_trap_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (trap_o == $past(trap_en && cond_d)));
endmodule

// File: tb/cond_select_unit_bench.sv
module cond_select_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_left = '0, op_right = '0, alu_out = '0;
  logic        is_sub = 1'b0, trap_en = 1'b0, hold_carry = 1'b0, reject = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic        cond_o, trap_o, carry_upd_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] code;
    logic       c;
    logic       t;
    logic       cu;
  } exp_t;
  exp_t sb_q[$];
  logic obs[16];

  always #5 clk = ~clk;

  cond_select_unit u_cond_select_unit (
    .clk(clk), .rst_n(rst_n), .op_left(op_left), .op_right(op_right),
    .alu_out(alu_out), .is_sub(is_sub), .cond_sel(cond_sel), .trap_en(trap_en),
    .hold_carry(hold_carry), .reject(reject), .cond_o(cond_o), .trap_o(trap_o),
    .carry_upd_o(carry_upd_o));

  function automatic string tag_of(input logic [3:0] code);
    case (code[2:0])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic model(input logic [3:0] code, input logic [31:0] l,
                                 input logic [31:0] r, input logic [31:0] o,
                                 input logic sub);
    logic [31:0] rr;
    logic v;
    rr = sub ? (32'd0 - r) : r;
    case (code)
      4'd0:  v = (o == 0);
      4'd8:  v = (o != 0);
      4'd1:  v = $signed(o) < 0;
      4'd9:  v = $signed(o) >= 0;
      4'd2:  v = $signed(o) <= 0;
      4'd10: v = $signed(o) > 0;
      4'd3:  v = (l[31] == rr[31]) && (o[31] != l[31]);
      4'd11: v = !((l[31] == rr[31]) && (o[31] != l[31]));
      4'd12: v = ($signed(l) >= 0) && ($signed(o) < 0);
      4'd4:  v = !(($signed(l) >= 0) && ($signed(o) < 0));
      4'd5:  v = (l[31] != l[30]) || (r[31] != r[30]) || (o[31] != o[30]);
      4'd13: v = (l[31] == l[30]) && (r[31] == r[30]) && (o[31] == o[30]);
      4'd6, 4'd7: v = 1'b0;
      default: v = 1'b1;
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, expv);
    end
  endtask

  // driver: present one operation, push its expected outcome
  task automatic drive(input logic [3:0] code, input logic [31:0] l, input logic [31:0] r,
                       input logic [31:0] o, input logic sub, input logic te,
                       input logic hc, input logic rj);
    exp_t e;
    @(negedge clk);
    cond_sel = code; op_left = l; op_right = r; alu_out = o; is_sub = sub;
    trap_en = te; hold_carry = hc; reject = rj;
    e.code = code;
    e.c  = model(code, l, r, o, sub);
    e.t  = te & e.c;
    e.cu = !(e.t || hc || rj);
    sb_q.push_back(e);
  endtask

  // monitor: results appear one edge after the driver's values are sampled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({tag_of(e.code), " cond R10"}, cond_o, e.c);
        check("R11 trap", trap_o, e.t);
        check("R12 carry", carry_upd_o, e.cu);
        obs[e.code] = cond_o;
      end
    end
  end

  task automatic sweep(input logic [31:0] l, input logic [31:0] r, input logic [31:0] o,
                       input logic sub);
    for (int c = 0; c < 16; c++) begin
      drive(c[3:0], l, r, o, sub, c[0], (c % 5) == 2, (c % 7) == 3);
    end
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < 8; c++) check("R9 complement", obs[c + 8], !obs[c]);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cond_sel = 4'd15; trap_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset cond", cond_o, 1'b0);
    check("R1 reset trap", trap_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 cond after release", cond_o, 1'b0);
    trap_en = 1'b0;
    // R10 latency: output holds until the next edge
    drive(4'd6, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    cond_sel = 4'd15;
    #3;
    check("R10 no early change", cond_o, 1'b0);
    @(posedge clk); #2;
    check("R10 after edge", cond_o, 1'b1);
    // operand patterns
    sweep(32'd5, 32'd3, 32'd8, 1'b0);
    sweep(32'd5, 32'd5, 32'd0, 1'b1);
    sweep(32'h7fff_ffff, 32'd1, 32'h8000_0000, 1'b0);
    sweep(32'h7fff_ffff, 32'd1, 32'h8000_0000, 1'b1);
    sweep(32'h8000_0000, 32'd1, 32'h7fff_ffff, 1'b1);
    sweep(32'd3, 32'd5, 32'hffff_fffe, 1'b1);
    sweep(32'h4000_0000, 32'd0, 32'd1, 1'b0);
    sweep(32'd1, 32'hbfff_ffff, 32'h3000_0000, 1'b0);
    sweep(32'hffff_fff0, 32'hffff_fff8, 32'hffff_ffe8, 1'b0);
    // R12 hold and reject block the carry with no trap
    drive(4'd6, 0, 0, 0, 0, 1, 1, 0);
    drive(4'd6, 0, 0, 0, 0, 1, 0, 1);
    drive(4'd15, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule